// File: doc/BRIEF.md
# Keyed Unlock Write-Enable Guard

This block guards the write-enable bit that lets software change the time-keeping counters of a real-time clock. The bit cannot be set by a plain configuration write. Software first writes two key bytes to a dedicated key register: the lock byte 0x55, then the unlock byte 0xAA. It then has a single clock cycle in which a configuration write that sets the enable bit takes effect. Any later attempt is dropped. Clearing the bit is always accepted, so software can lock the counters again at any time.

The guard watches the bus write strobes and data for the key register and the configuration register. It holds the enable level in a register and exposes it. It also applies that level to a vector of timer write strobes, one per timer register pair. While the enable is low those strobes are silently dropped. Reads never pass through the guard and are never blocked.

Top module: `unlock_wen_guard`

## Requirements
- R1: After a synchronous active-high reset, `wen_o` is 0 and the key detector is idle. A configuration write setting bit 13 in the first cycle after reset has no effect.
- R2: A key write of 0x55, then a key write of 0xAA, then in the very next cycle a configuration write with bit 13 = 1, makes `wen_o` read 1 from the following cycle on.
- R3: If one or more cycles pass between the 0xAA key write and the configuration write setting bit 13, the set is ignored and `wen_o` stays 0.
- R4: A configuration write with bit 13 = 1 and no preceding key sequence leaves `wen_o` unchanged. When `wen_o` is already 1 it stays 1.
- R5: After 0x55, a key write of any value other than 0x55 or 0xAA returns the detector to idle, so a following 0xAA does not open the window. A lone 0xAA from idle also opens nothing.
- R6: A key write of 0x55 in any detector state, including the window cycle, restarts the sequence. 0x55, 0x55, 0xAA therefore still opens the window.
- R7: A configuration write with bit 13 = 0 always clears `wen_o` on the next cycle, whatever the detector state. Without a configuration write, `wen_o` keeps its value.
- R8: Each bit of `tmr_wr_o` equals the matching bit of `tmr_wr_i` while `wen_o` is 1, and is 0 while `wen_o` is 0.
- R9: Only bit 13 of the configuration write data acts on the guard. A write in the window with bit 13 = 0 and every other bit 1 does not set the enable.
- R10: Cycles without a key write between 0x55 and 0xAA do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Write strobe of the key register |
| key_wdata | input | 8 | Key register write data |
| cfg_we | input | 1 | Write strobe of the configuration register |
| cfg_wdata | input | 16 | Configuration write data; bit 13 is the enable request |
| tmr_wr_i | input | 4 | Timer register write strobes from the register window |
| wen_o | output | 1 | Registered timer write-enable level |
| tmr_wr_o | output | 4 | Timer write strobes after gating by the enable |

## Verification
The assertions check on every cycle the properties that depend only on the last one or two cycles:
- clearing always works;
- the enable never rises without a set request and an unlock byte two cycles earlier;
- the enable holds when no configuration write occurs;
- gated strobes never pass while the enable is low;
- the enable is low right after reset.

Only the bench scenarios show the parts that depend on the detector's history: missed windows, broken and restarted sequences, idle gaps between key bytes, and the exact cycle in which the enable first reads 1.

// File: rtl/uwg_pkg.sv
package uwg_pkg;
  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_FIRST = 2'd1,
    KS_OPEN  = 2'd2
  } key_state_t;
endpackage

// File: rtl/uwg_key_fsm.sv
module uwg_key_fsm
  import uwg_pkg::*;
#(
  parameter int          KEY_W    = 8,
  parameter logic [KEY_W-1:0] LOCK_B   = 8'h55,
  parameter logic [KEY_W-1:0] UNLOCK_B = 8'hAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  output logic             window_o
);
  key_state_t cur_q, nxt_d;

  always_comb begin
    nxt_d = cur_q;
    // the open window lives for exactly one cycle
    if (cur_q == KS_OPEN) nxt_d = KS_IDLE;
    if (key_we) begin
      if (key_wdata == LOCK_B)
        nxt_d = KS_FIRST;
      else if (cur_q == KS_FIRST && key_wdata == UNLOCK_B)
        nxt_d = KS_OPEN;
      else
        nxt_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= KS_IDLE;
    else     cur_q <= nxt_d;
  end

  assign window_o = (cur_q == KS_OPEN);
endmodule

// File: rtl/uwg_enable_reg.sv
module uwg_enable_reg #(
  parameter int CFG_W  = 16,
  parameter int EN_BIT = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             window_i,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             wen_o
);
  logic req_bit;
  logic cfg_unused;

  assign req_bit    = cfg_wdata[EN_BIT];
  assign cfg_unused = ^{cfg_wdata[CFG_W-1:EN_BIT+1], cfg_wdata[EN_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst)
      wen_o <= 1'b0;
    else if (cfg_we) begin
      if (!req_bit)
        wen_o <= 1'b0;        // lock: always honoured
      else if (window_i)
        wen_o <= 1'b1;        // unlock: only inside the window
    end
  end
endmodule

// File: rtl/uwg_write_gate.sv
module uwg_write_gate #(
  parameter int TMR_W = 4
) (
  input  logic             wen_i,
  input  logic [TMR_W-1:0] wr_i,
  output logic [TMR_W-1:0] wr_o
);
  for (genvar g = 0; g < TMR_W; g++) begin : g_lane
    assign wr_o[g] = wr_i[g] & wen_i;
  end
endmodule

// File: rtl/unlock_wen_guard.sv
module unlock_wen_guard #(
  parameter int          KEY_W    = 8,
  parameter logic [KEY_W-1:0] LOCK_B   = 8'h55,
  parameter logic [KEY_W-1:0] UNLOCK_B = 8'hAA,
  parameter int          CFG_W    = 16,
  parameter int          EN_BIT   = 13,
  parameter int          TMR_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [TMR_W-1:0] tmr_wr_i,
  output logic             wen_o,
  output logic [TMR_W-1:0] tmr_wr_o
);
  logic window;

  uwg_key_fsm #(
    .KEY_W(KEY_W), .LOCK_B(LOCK_B), .UNLOCK_B(UNLOCK_B)
  ) u_fsm (
    .clk(clk), .rst(rst), .key_we(key_we), .key_wdata(key_wdata),
    .window_o(window)
  );

  uwg_enable_reg #(
    .CFG_W(CFG_W), .EN_BIT(EN_BIT)
  ) u_en (
    .clk(clk), .rst(rst), .window_i(window), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .wen_o(wen_o)
  );

  uwg_write_gate #(
    .TMR_W(TMR_W)
  ) u_gate (
    .wen_i(wen_o), .wr_i(tmr_wr_i), .wr_o(tmr_wr_o)
  );
endmodule

// File: rtl/uwg_checker.sv
module uwg_checker #(
  parameter int          KEY_W    = 8,
  parameter logic [KEY_W-1:0] UNLOCK_B = 8'hAA,
  parameter int          TMR_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             key_we,
  input logic [KEY_W-1:0] key_wdata,
  input logic             cfg_we,
  input logic             cfg_req,
  input logic [TMR_W-1:0] tmr_wr_o,
  input logic             wen_o
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wen_o);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_req) |=> !wen_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(wen_o));

  assert_rise_needs_set_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wen_o) |-> $past(cfg_we && cfg_req));

  assert_rise_needs_unlock_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wen_o) |-> $past(key_we && key_wdata == UNLOCK_B, 2));

  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    !wen_o |-> (tmr_wr_o == '0));
endmodule

bind unlock_wen_guard uwg_checker #(
  .KEY_W(KEY_W), .UNLOCK_B(UNLOCK_B), .TMR_W(TMR_W)
) u_chk (
  .clk(clk), .rst(rst), .key_we(key_we), .key_wdata(key_wdata),
  .cfg_we(cfg_we), .cfg_req(cfg_wdata[EN_BIT]), .tmr_wr_o(tmr_wr_o),
  .wen_o(wen_o)
);

// File: tb/tb_unlock_wen_guard.sv
module tb_unlock_wen_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_we = 1'b0;
  logic [7:0] key_wdata = '0;
  logic       cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0] tmr_wr_i = '0;
  logic       wen_o;
  logic [3:0] tmr_wr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       en;
    logic [3:0] gate;
    string      tag;
  } exp_t;
  exp_t sb[$];

  unlock_wen_guard dut (
    .clk(clk), .rst(rst), .key_we(key_we), .key_wdata(key_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .tmr_wr_i(tmr_wr_i),
    .wen_o(wen_o), .tmr_wr_o(tmr_wr_o)
  );

  always #10 clk = ~clk;

  // monitor: compares the design's outputs mid-cycle against the scoreboard
  always @(posedge clk) begin
    #5;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (wen_o !== e.en || tmr_wr_o !== e.gate) begin
        errors++;
        $display("FAIL %s: wen_o=%0b tmr_wr_o=%b expected wen_o=%0b tmr_wr_o=%b",
                 e.tag, wen_o, tmr_wr_o, e.en, e.gate);
      end
    end
  end

  task automatic step(input logic kw, input logic [7:0] kd, input logic cw,
                      input logic [15:0] cd, input logic [3:0] tm,
                      input logic een, input string tag);
    exp_t e;
    @(negedge clk);
    key_we = kw; key_wdata = kd; cfg_we = cw; cfg_wdata = cd; tmr_wr_i = tm;
    e.en = een; e.gate = tm & {4{een}}; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic key(input logic [7:0] v, input logic een, input string tag);
    step(1'b1, v, 1'b0, 16'h0, 4'h0, een, tag);
  endtask
  task automatic cfg(input logic [15:0] v, input logic een, input string tag);
    step(1'b0, 8'h0, 1'b1, v, 4'h0, een, tag);
  endtask
  task automatic idle(input logic een, input string tag);
    step(1'b0, 8'h0, 1'b0, 16'h0, 4'h0, een, tag);
  endtask
  task automatic tmr(input logic [3:0] m, input logic een, input string tag);
    step(1'b0, 8'h0, 1'b0, 16'h0, m, een, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (wen_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: wen_o=%0b expected 0 in reset", wen_o);
    end
    @(negedge clk); rst = 1'b0;

    cfg(16'h2000, 1'b0, "R1 set right after reset");
    cfg(16'h2000, 1'b0, "R4 set without key");
    key(8'h55, 1'b0, "R2 lock byte");
    key(8'hAA, 1'b0, "R2 unlock byte");
    cfg(16'h2000, 1'b1, "R2 set in window");
    tmr(4'b1011, 1'b1, "R8 strobes pass");
    cfg(16'h2000, 1'b1, "R4 set while enabled keeps 1");
    cfg(16'h0000, 1'b0, "R7 clear");
    tmr(4'b1111, 1'b0, "R8 strobes blocked");
    key(8'h55, 1'b0, "R3 lock");
    key(8'hAA, 1'b0, "R3 unlock");
    idle(1'b0, "R3 gap cycle");
    cfg(16'h2000, 1'b0, "R3 late set ignored");
    key(8'h55, 1'b0, "R5 lock");
    key(8'h12, 1'b0, "R5 wrong byte");
    key(8'hAA, 1'b0, "R5 unlock after break");
    cfg(16'h2000, 1'b0, "R5 set after broken sequence");
    key(8'hAA, 1'b0, "R5 lone unlock");
    cfg(16'h2000, 1'b0, "R5 set after lone unlock");
    key(8'h55, 1'b0, "R10 lock");
    idle(1'b0, "R10 gap");
    idle(1'b0, "R10 gap");
    key(8'hAA, 1'b0, "R10 unlock");
    cfg(16'h2000, 1'b1, "R10 set after gapped sequence");
    cfg(16'hDFFF, 1'b0, "R7 R9 clear with other bits set");
    key(8'h55, 1'b0, "R9 lock");
    key(8'hAA, 1'b0, "R9 unlock");
    cfg(16'hDFFF, 1'b0, "R9 window write without bit 13");
    key(8'h55, 1'b0, "R6 lock");
    key(8'h55, 1'b0, "R6 lock again");
    key(8'hAA, 1'b0, "R6 unlock");
    cfg(16'h2000, 1'b1, "R6 set after repeated lock");
    cfg(16'h0000, 1'b0, "R7 clear again");
    key(8'h55, 1'b0, "R6 lock");
    key(8'hAA, 1'b0, "R6 unlock");
    key(8'h55, 1'b0, "R6 lock in window");
    key(8'hAA, 1'b0, "R6 unlock again");
    cfg(16'h2000, 1'b1, "R6 set after restart from window");
    tmr(4'b0110, 1'b1, "R8 strobes pass again");
    cfg(16'h0000, 1'b0, "R7 final clear");
    key(8'h55, 1'b0, "R1 lock before reset");
    key(8'hAA, 1'b0, "R1 unlock before reset");
    @(negedge clk);
    key_we = 1'b0; rst = 1'b1;
    @(posedge clk); #5;
    @(negedge clk); rst = 1'b0;
    cfg(16'h2000, 1'b0, "R1 reset closes window");
    idle(1'b0, "R1 stays clear");
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule